// File: doc/BRIEF.md
# Multichannel PCM Serial Audio Transmitter

This block accepts 32-bit PCM words written into a small internal FIFO by a bus master or DMA engine. It sends them out as a serial audio stream that it clocks itself: a bit clock divided down from the system clock, a left/right word clock, and one serial data line. One, two or three stereo channel pairs can share the line. Samples can be 16 bits wide, with a left/right pair packed into each FIFO word. They can also be 17 to 24 bits wide, with one sample per word.

Each collection sends every left sample of the enabled pairs first, then the right samples in the same pair order. Each slot is 32 bit clocks wide, and the first slot after a start is always a left slot. If the FIFO runs dry, silence is sent and a sticky underflow flag is set. A write into a full FIFO is thrown away and sets a sticky overflow flag. When `run` drops, the collection in flight is finished before the serial pins go quiet. A refill request stays high while any FIFO word is free.

Top module: `pcm_serial_tx`

## Requirements
- R1: While busy, `bitclk` toggles every BCLK_HALF system cycles. While idle it rests low and does not toggle.
- R2: `lrclk` is low during left slots and high during right slots. It changes only as `bitclk` falls. Each slot is 32 bit clocks wide. The slot's MSB appears on `sdata` one bit clock after the `lrclk` change, and bits past the sample width are sent as 0.
- R3: With `wide_mode`=0, the sample width is 16. A FIFO word supplies the left sample from bits 15:0 and the right sample of the same pair from bits 31:16.
- R4: With `wide_mode`=1, each FIFO word holds one sample, right-justified from bit 0. Its width is `sample_bits` limited to the range 17..24, and bits above that width are ignored.
- R5: `pair_count` 1, 2 or 3 (0 acts as 1) sets the number of pairs. A collection sends left slots of pairs 0..N-1, then right slots of pairs 0..N-1. Wide mode takes one word per slot. Packed mode takes one word per left slot. The mode, width and pair count are sampled at the start of each collection.
- R6: A start from idle begins with a left slot, so `lrclk` is low in the first busy cycle.
- R7: A word needed while the FIFO is empty is replaced by a zero sample. This sets `underflow`, which stays set until cleared and drives `irq`.
- R8: A write while `fill_level` equals FIFO_DEPTH is dropped, and the stored words are kept. This sets `overflow`, which stays set until cleared and drives `irq`.
- R9: When `run` is low at the end of a collection, the block goes idle. It then holds `bitclk` low, `lrclk` high and `sdata` low.
- R10: `fill_req` is high whenever `fill_level` is below FIFO_DEPTH.
- R11: `flag_clear` bit 0 clears `underflow` and bit 1 clears `overflow`; a new event in the same cycle wins. `fifo_clear` empties the FIFO, and a write in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Start transmission / request a stop at the end of the collection |
| wide_mode | input | 1 | 0: 16-bit packed pairs, 1: one 17..24-bit sample per word |
| sample_bits | input | 5 | Sample width in wide mode |
| pair_count | input | 2 | Number of stereo pairs, 1..3 |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| fifo_clear | input | 1 | Empty the FIFO |
| flag_clear | input | 2 | Write-one-to-clear: bit 0 underflow, bit 1 overflow |
| bitclk | output | 1 | Serial bit clock |
| lrclk | output | 1 | Word clock, low for left slots |
| sdata | output | 1 | Serial data, MSB first |
| busy | output | 1 | Serializer is active |
| fill_req | output | 1 | At least one FIFO word is free |
| irq | output | 1 | Underflow or overflow flag set |
| underflow | output | 1 | Sticky underflow flag |
| overflow | output | 1 | Sticky overflow flag |
| fill_level | output | $clog2(FIFO_DEPTH+1) | Words held in the FIFO |

## Verification
Several rules are checked by assertions on every cycle. The bit clock may change only on a divider tick, and the word clock may move only while the bit clock is low. The quiet idle levels, the left first slot, stickiness of the flags and the occupancy cap are also checked this way. FIFO pops may happen only on a serializer step, a full FIFO must keep its level through a dropped write, and a FIFO clear must empty it. The ordering of pairs, packed halfword selection, width clamping, zero padding, silence on underflow and the completion of a collection after `run` drops are bit-level sequence properties. Only the bench's reference model shows these, by comparing every output on every cycle across its scenarios.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  localparam int SMP_MAX = 24;
  localparam int PACK_W  = 16;
  localparam int PAIR_MAX = 3;

  // Effective sample width: 16 in packed mode, clamped 17..24 in wide mode.
  function automatic logic [4:0] eff_width(input logic wide, input logic [4:0] req);
    if (!wide)            return 5'd16;
    else if (req < 5'd17) return 5'd17;
    else if (req > 5'd24) return 5'd24;
    else                  return req;
  endfunction

  // Effective pair count: zero is treated as one.
  function automatic logic [1:0] eff_pairs(input logic [1:0] req);
    return (req == 2'd0) ? 2'd1 : req;
  endfunction

  // Keep the low w bits and move the sample MSB to bit 23.
  function automatic logic [23:0] msb_align(input logic [23:0] smp, input logic [4:0] w);
    logic [23:0] keep;
    keep = 24'hFF_FFFF >> (5'd24 - w);
    return (smp & keep) << (5'd24 - w);
  endfunction

endpackage

// File: rtl/pcm_tx_fifo.sv
module pcm_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr,
  input  logic [WIDTH-1:0]           wdata,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_q, wr_q;
  logic [LW-1:0]    cnt_q;
  logic             do_wr, do_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign do_wr = wr && !full && !clr;
  assign do_rd = pop && !empty && !clr;
  assign drop  = wr && full && !clr;
  assign head  = mem[rd_q];
  assign level = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wr_q <= nxt(wr_q);
      if (do_rd) rd_q <= nxt(rd_q);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_q] <= wdata;
  end

endmodule

// File: rtl/pcm_tx_bclk_gen.sv
module pcm_tx_bclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic bclk,
  output logic half_tick,
  output logic fall_tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          bclk_q;

  assign half_tick = active && (cnt_q == CW'(HALF - 1));
  assign fall_tick = half_tick && bclk_q;
  assign bclk      = bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!active) begin
      cnt_q  <= '0;
    end else if (half_tick) begin
      cnt_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

endmodule

// File: rtl/pcm_tx_slot_seq.sv
module pcm_tx_slot_seq
  import pcm_tx_pkg::*;
#(
  parameter int SLOT_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        wide_in,
  input  logic [4:0]  bits_in,
  input  logic [1:0]  pairs_in,
  input  logic        fall_tick,
  input  logic [31:0] head,
  input  logic        empty,
  output logic        active,
  output logic        step,
  output logic        pop_req,
  output logic        starve,
  output logic        lrclk,
  output logic        sdata
);
  localparam int BW = $clog2(SLOT_LEN);

  logic          active_q, wide_q, pend_q, lr_q, sd_q;
  logic [2:0]    slot_q;
  logic [BW-1:0] bit_q;
  logic [1:0]    pairs_q;
  logic [4:0]    w_q;
  logic [23:0]   sh_q;
  logic [15:0]   hold_q [4];

  logic          start, last_bit, last_slot, wrap, stop, new_coll;
  logic [1:0]    use_pairs;
  logic          use_wide;
  logic [4:0]    use_w;
  logic [2:0]    nslot;
  logic [BW-1:0] nbit;
  logic          load, is_left, cur;
  logic [1:0]    ridx;
  logic [31:0]   entry;
  logic [23:0]   sample, loaded;

  assign start     = !active_q && run;
  assign last_bit  = (bit_q == BW'(SLOT_LEN - 1));
  assign last_slot = (slot_q == ({pairs_q, 1'b0} - 3'd1));
  assign wrap      = active_q && fall_tick && last_bit && last_slot;
  assign stop      = wrap && !run;
  assign step      = start || (active_q && fall_tick);
  assign new_coll  = start || (wrap && run);

  // Configuration is frozen for a whole collection.
  assign use_pairs = new_coll ? eff_pairs(pairs_in) : pairs_q;
  assign use_wide  = new_coll ? wide_in : wide_q;
  assign use_w     = new_coll ? eff_width(wide_in, bits_in) : w_q;

  assign nslot   = new_coll ? 3'd0 : (last_bit ? slot_q + 3'd1 : slot_q);
  assign nbit    = (new_coll || last_bit) ? '0 : bit_q + BW'(1);
  assign load    = step && !stop && (nbit == '0);
  assign is_left = (nslot < {1'b0, use_pairs});
  assign ridx    = 2'(nslot - {1'b0, use_pairs});

  assign pop_req = load && (use_wide || is_left);
  assign starve  = pop_req && empty;
  assign entry   = starve ? 32'd0 : head;

  always_comb begin
    if (use_wide)     sample = entry[23:0];
    else if (is_left) sample = {8'd0, entry[15:0]};
    else              sample = {8'd0, hold_q[ridx]};
  end

  assign loaded = msb_align(sample, use_w);
  assign cur    = load ? loaded[23] : sh_q[23];

  assign active = active_q;
  assign lrclk  = lr_q;
  assign sdata  = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      bit_q    <= '0;
      pairs_q  <= 2'd1;
      wide_q   <= 1'b0;
      w_q      <= 5'd16;
      sh_q     <= '0;
      pend_q   <= 1'b0;
      lr_q     <= 1'b1;
      sd_q     <= 1'b0;
    end else if (step) begin
      if (stop) begin
        active_q <= 1'b0;
        pend_q   <= 1'b0;
        sd_q     <= 1'b0;
        sh_q     <= '0;
      end else begin
        active_q <= 1'b1;
        slot_q   <= nslot;
        bit_q    <= nbit;
        pairs_q  <= use_pairs;
        wide_q   <= use_wide;
        w_q      <= use_w;
        lr_q     <= !is_left;
        sd_q     <= pend_q;
        pend_q   <= cur;
        sh_q     <= load ? (loaded << 1) : (sh_q << 1);
      end
    end
  end

  // Right halves of packed words wait here until the right phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) hold_q[i] <= '0;
    end else if (load && !use_wide && is_left) begin
      for (int i = 0; i < PAIR_MAX; i++)
        if (nslot == 3'(i)) hold_q[i] <= entry[31:16];
    end
  end

endmodule

// File: rtl/pcm_tx_status.sv
module pcm_tx_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uf_set,
  input  logic       of_set,
  input  logic [1:0] clr,
  output logic       uflow,
  output logic       oflow,
  output logic       irq
);
  logic uf_q, of_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q <= 1'b0;
      of_q <= 1'b0;
    end else begin
      uf_q <= uf_set || (uf_q && !clr[0]);
      of_q <= of_set || (of_q && !clr[1]);
    end
  end

  assign uflow = uf_q;
  assign oflow = of_q;
  assign irq   = uf_q || of_q;

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx #(
  parameter int FIFO_DEPTH = 8,
  parameter int BCLK_HALF  = 2,
  parameter int SLOT_LEN   = 32,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wide_mode,
  input  logic [4:0]    sample_bits,
  input  logic [1:0]    pair_count,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          fifo_clear,
  input  logic [1:0]    flag_clear,
  output logic          bitclk,
  output logic          lrclk,
  output logic          sdata,
  output logic          busy,
  output logic          fill_req,
  output logic          irq,
  output logic          underflow,
  output logic          overflow,
  output logic [LW-1:0] fill_level
);
  // Internal events brought out by name for the checker.
  logic        half_tick_w, fall_tick_w, step_w, pop_req_w, starve_w, drop_w;
  logic        full_w, empty_w, active_w;
  logic [31:0] head_w;

  pcm_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clear), .wr(wr_en), .wdata(wr_data),
    .pop(pop_req_w), .head(head_w), .level(fill_level), .full(full_w),
    .empty(empty_w), .drop(drop_w)
  );

  pcm_tx_bclk_gen #(.HALF(BCLK_HALF)) u_bclk (
    .clk(clk), .rst_n(rst_n), .active(active_w), .bclk(bitclk),
    .half_tick(half_tick_w), .fall_tick(fall_tick_w)
  );

  pcm_tx_slot_seq #(.SLOT_LEN(SLOT_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .wide_in(wide_mode),
    .bits_in(sample_bits), .pairs_in(pair_count), .fall_tick(fall_tick_w),
    .head(head_w), .empty(empty_w), .active(active_w), .step(step_w),
    .pop_req(pop_req_w), .starve(starve_w), .lrclk(lrclk), .sdata(sdata)
  );

  pcm_tx_status u_stat (
    .clk(clk), .rst_n(rst_n), .uf_set(starve_w), .of_set(drop_w),
    .clr(flag_clear), .uflow(underflow), .oflow(overflow), .irq(irq)
  );

  assign busy     = active_w;
  assign fill_req = !full_w;

endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          fifo_clear,
  input logic [1:0]    flag_clear,
  input logic          bitclk,
  input logic          lrclk,
  input logic          sdata,
  input logic          busy,
  input logic          irq,
  input logic          underflow,
  input logic          overflow,
  input logic [LW-1:0] fill_level,
  input logic          half_tick,
  input logic          step,
  input logic          pop_req
);

  a_r1_bclk_paced: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bitclk) |-> $past(half_tick));

  a_r2_lr_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrclk) |-> !bitclk);

  a_r5_pop_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req |-> step);

  a_r6_first_left: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !lrclk);

  a_r7_uflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !flag_clear[0] |=> underflow);

  a_r7_uflow_irq: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> irq);

  a_r8_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
    fill_level <= LW'(DEPTH));

  a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == LW'(DEPTH)) && !pop_req && !fifo_clear |=> fill_level == LW'(DEPTH));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bitclk && lrclk && !sdata);

  a_r11_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clear |=> fill_level == '0);

  a_r11_oflow_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clear[1] && !(wr_en && fill_level == LW'(DEPTH)) |=> !overflow);

endmodule

bind pcm_serial_tx pcm_serial_tx_chk #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fifo_clear(fifo_clear),
  .flag_clear(flag_clear), .bitclk(bitclk), .lrclk(lrclk), .sdata(sdata),
  .busy(busy), .irq(irq), .underflow(underflow), .overflow(overflow),
  .fill_level(fill_level), .half_tick(half_tick_w), .step(step_w),
  .pop_req(pop_req_w)
);

// File: tb/tb_pcm_serial_tx.sv
module tb_pcm_serial_tx;
  localparam int DEPTH = 8;
  localparam int HALF  = 2;
  localparam int LW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, wide_mode = 1'b0, wr_en = 1'b0, fifo_clear = 1'b0;
  logic [4:0] sample_bits = 5'd16;
  logic [1:0] pair_count = 2'd1, flag_clear = 2'd0;
  logic [31:0] wr_data = '0;
  logic bitclk, lrclk, sdata, busy, fill_req, irq, underflow, overflow;
  logic [LW-1:0] fill_level;

  always #10 clk = ~clk;

  pcm_serial_tx #(.FIFO_DEPTH(DEPTH), .BCLK_HALF(HALF), .SLOT_LEN(32)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .wide_mode(wide_mode),
    .sample_bits(sample_bits), .pair_count(pair_count), .wr_en(wr_en),
    .wr_data(wr_data), .fifo_clear(fifo_clear), .flag_clear(flag_clear),
    .bitclk(bitclk), .lrclk(lrclk), .sdata(sdata), .busy(busy),
    .fill_req(fill_req), .irq(irq), .underflow(underflow),
    .overflow(overflow), .fill_level(fill_level)
  );

  int tests = 0, fails = 0;
  bit cmp_on = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int      q[$];
  bit      slot_bits[$];
  bit      m_act, m_bclk, m_lr, m_sd, m_pend, m_uf, m_of, m_wide;
  int      m_cnt, m_slot, m_bit, m_pairs, m_w;
  int      m_hold[3];

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); slot_bits.delete();
      m_act = 0; m_bclk = 0; m_lr = 1; m_sd = 0; m_pend = 0; m_uf = 0; m_of = 0;
      m_cnt = 0; m_slot = 0; m_bit = 0; m_pairs = 1; m_w = 16; m_wide = 0;
      for (int i = 0; i < 3; i++) m_hold[i] = 0;
    end else begin
      bit was_full, go, fall, newc, quit, starve;
      was_full = (q.size() == DEPTH);
      go   = !m_act && run;
      fall = m_act && (m_cnt == HALF - 1) && m_bclk;
      starve = 0;
      if (m_act) begin
        if (m_cnt == HALF - 1) begin m_cnt = 0; m_bclk = !m_bclk; end
        else m_cnt++;
      end else m_cnt = 0;
      if (go || fall) begin
        newc = go; quit = 0;
        if (!go && m_bit == 31 && m_slot == 2 * m_pairs - 1) begin
          if (run) newc = 1; else quit = 1;
        end
        if (quit) begin
          m_act = 0; m_sd = 0; m_pend = 0; slot_bits.delete();
        end else begin
          if (newc) begin
            m_pairs = (pair_count == 0) ? 1 : pair_count;
            m_wide  = wide_mode;
            m_w     = !wide_mode ? 16 : (sample_bits < 17 ? 17 : (sample_bits > 24 ? 24 : sample_bits));
            m_slot = 0; m_bit = 0;
          end else if (m_bit == 31) begin m_slot++; m_bit = 0; end
          else m_bit++;
          if (m_bit == 0) begin
            int word, smp;
            bit left;
            left = (m_slot < m_pairs);
            word = 0;
            if (m_wide || left) begin
              if (q.size() == 0) starve = 1;
              else begin word = q[0]; if (!fifo_clear) void'(q.pop_front()); end
            end
            if (m_wide) smp = word & ((1 << m_w) - 1);
            else if (left) begin smp = word & 32'hFFFF; m_hold[m_slot] = (word >> 16) & 32'hFFFF; end
            else smp = m_hold[m_slot - m_pairs];
            slot_bits.delete();
            for (int i = 0; i < 32; i++)
              slot_bits.push_back(i < m_w ? bit'((smp >> (m_w - 1 - i)) & 1) : 1'b0);
          end
          m_lr = !(m_slot < m_pairs);
          m_sd = m_pend;
          m_pend = slot_bits.pop_front();
          m_act = 1;
        end
      end
      if (fifo_clear) q.delete();
      else if (wr_en && !was_full) q.push_back(wr_data);
      m_uf = starve || (m_uf && !flag_clear[0]);
      m_of = (wr_en && was_full && !fifo_clear) || (m_of && !flag_clear[1]);
    end
  end

  // Every-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1 bitclk", bitclk, m_bclk);
      chk("R2 R6 lrclk", lrclk, m_lr);
      chk("R2 R3 R4 R5 R7 sdata", sdata, m_sd);
      chk("R9 busy", busy, m_act);
      chk("R7 R11 underflow", underflow, m_uf);
      chk("R8 R11 overflow", overflow, m_of);
      chk("R7 R8 irq", irq, m_uf | m_of);
      chk("R10 fill_req", fill_req, q.size() < DEPTH);
      chk("R8 R11 fill_level", fill_level, q.size());
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    chk("R9 stop completes", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(4);
    rst_n = 1;
    @(negedge clk);
    cmp_on = 1;
    // reset state
    chk("R1 reset bitclk", bitclk, 0);
    chk("R9 reset lrclk", lrclk, 1);
    chk("R9 reset sdata", sdata, 0);
    chk("R10 reset fill_req", fill_req, 1);
    chk("R7 reset irq", irq, 0);

    // R8: overflow while stopped, stored data kept
    for (int i = 0; i < 9; i++) put(32'h8001_4003 ^ (i * 32'h1357_2468));
    chk("R8 level at full", fill_level, DEPTH);
    chk("R8 overflow set", overflow, 1);
    chk("R10 fill_req low when full", fill_req, 0);
    @(negedge clk); flag_clear = 2'b10; @(negedge clk); flag_clear = 2'b00;
    chk("R11 overflow cleared", overflow, 0);

    // R3 R5 R6: packed, one pair, drain and underflow
    wide_mode = 0; pair_count = 2'd1;
    run = 1; @(negedge clk);
    chk("R6 first slot left", lrclk, 0);
    chk("R6 busy after start", busy, 1);
    cyc(2600);
    chk("R7 underflow after drain", underflow, 1);
    chk("R7 irq after drain", irq, 1);
    run = 0; wait_idle();
    cyc(20);
    chk("R9 idle bitclk", bitclk, 0);
    chk("R9 idle lrclk", lrclk, 1);
    @(negedge clk); flag_clear = 2'b01; @(negedge clk); flag_clear = 2'b00;
    chk("R11 underflow cleared", underflow, 0);

    // R4 R5: wide 20-bit, three pairs, garbage upper bits, refill mid-run
    wide_mode = 1; sample_bits = 5'd20; pair_count = 2'd3;
    for (int i = 0; i < 8; i++) put(32'hFF00_0000 | (32'h5A5A5 + i * 32'h1F3C1));
    run = 1;
    cyc(300);
    for (int i = 0; i < 6; i++) put(32'hC3F0_0000 ^ (i * 32'h0B0D_0F11));
    cyc(900);
    run = 0; wait_idle();

    // R11: FIFO clear
    for (int i = 0; i < 3; i++) put(32'h1234_5678 + i);
    @(negedge clk); fifo_clear = 1; wr_en = 1; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); fifo_clear = 0; wr_en = 0;
    chk("R11 fifo cleared", fill_level, 0);

    // R4 R5: width clamp to 24, two pairs; then pair_count 0 in packed mode
    wide_mode = 1; sample_bits = 5'd30; pair_count = 2'd2;
    for (int i = 0; i < 8; i++) put(32'hABCD_EF01 ^ (i * 32'h0111_1111));
    run = 1; cyc(200);
    wide_mode = 0; pair_count = 2'd0;
    cyc(900);
    for (int i = 0; i < 4; i++) put(32'h7FFF_8000 + i * 32'h0003_0005);
    cyc(1200);
    run = 0; wait_idle();

    // R2 R5: packed, two pairs, keep fed
    pair_count = 2'd2;
    for (int i = 0; i < 6; i++) put(32'h0F0F_F0F0 ^ (i * 32'h2222_1111));
    run = 1; cyc(700);
    run = 0; wait_idle();
    cyc(10);

    cmp_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule